// File: doc/BRIEF.md
# Three-Region Memory with OR-Merged Read Bus

This block is a small on-chip memory subsystem for a simple processor bus. One address bus, one write-data bus, a write strobe and a read strobe serve three synchronous RAM regions. A decoder looks at the two most significant address bits and raises exactly one region select. Each region's write enable is its select combined with the write strobe. Each region's output enable is its select combined with the read strobe.

Every region registers its read word. On any clock edge where a region is not enabled for output, that region's output register is cleared through its synchronous reset path. This means only the region being read presents a non-zero word, so the shared read bus is a plain bitwise OR of the three region outputs. No select-driven multiplexer is needed. Read data appears one clock after the address and read strobe are presented.

Top module: `orbus_mem`

## Requirements
- R1: Address bits [9:8] pick the region: 00 selects region A (256 words, index addr[7:0]), 01 selects region B (256 words, index addr[7:0]), and 1x selects region C (512 words, index addr[8:0]). Each of the 1024 addresses therefore maps to its own storage word.
- R2: Exactly one region select is active for every address value.
- R3: With `wr_en` high at a rising edge, `wdata` is stored at the addressed word of the selected region only.
- R4: With `rd_en` high at a rising edge, `rdata` holds the addressed stored word from that edge until the next edge.
- R5: With `rd_en` low at a rising edge, `rdata` is zero from that edge until the next edge.
- R6: Every region that is not being read drives zero, and `rdata` is the bitwise OR of all region outputs. Reading one word never shows bits of a word stored in another region.
- R7: While `rst` is high, `rdata` is zero at each edge, even with `rd_en` high.
- R8: If a read and a write to the same address happen on the same edge, `rdata` shows the contents from before that write, and a later read returns the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the output registers |
| addr | input | 10 | Word address; the top two bits pick the region |
| wdata | input | 16 | Write-data word |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 16 | Read-data bus, the OR of the three region outputs |

## Verification
Every one of the 1024 addresses is written with its own pattern, computed as an odd multiple of the address plus an offset. All addresses are then read back. Because all patterns differ, a wrong decode, a wrong index slice or a region that fails to clear its output shows up as a mismatched or OR-corrupted word. Idle cycles with the read strobe low separate the zeroing path from the data path. A read issued during reset shows that reset overrides the strobe. A read and write to one address on the same edge shows that the register samples the old contents.

// File: rtl/orbus_pkg.sv
package orbus_pkg;

    localparam int NUM_RGN = 3;

    typedef enum logic [1:0] {
        RGN_A = 2'd0,
        RGN_B = 2'd1,
        RGN_C = 2'd2
    } rgn_e;

    // Index width of a region: the large region uses one more bit.
    function automatic int rgn_idx_w(input int rgn, input int addr_w);
        return (rgn == int'(RGN_C)) ? addr_w - 1 : addr_w - 2;
    endfunction

endpackage

// File: rtl/orbus_decode.sv
module orbus_decode
    import orbus_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          top_bits,
    output logic [NUM_RGN-1:0]  sel
);

    always_comb begin
        sel = '0;
        unique casez (top_bits)
            2'b00:   sel[RGN_A] = 1'b1;
            2'b01:   sel[RGN_B] = 1'b1;
            2'b1?:   sel[RGN_C] = 1'b1;
            default: sel = '0;
        endcase
    end

    // R2: one and only one select for any address
    assert_one_select_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(sel) == 1);

    // R1: upper half of the address space belongs to region C
    assert_upper_half_c_R1: assert property (@(posedge clk) disable iff (rst)
        top_bits[1] |-> sel[RGN_C]);

endmodule

// File: rtl/orbus_region.sv
module orbus_region #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              oe,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[idx] <= din;
        end
    end

    // Output register: cleared through its reset path when not read.
    always_ff @(posedge clk) begin
        if (rst || !oe) begin
            dout <= '0;
        end else begin
            dout <= store[idx];
        end
    end

    // R6: a region not read on the last edge drives zero
    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(oe) |-> (dout == '0));

endmodule

// File: rtl/orbus_mem.sv
module orbus_mem
    import orbus_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata
);

    logic [NUM_RGN-1:0] sel;
    logic [DATA_W-1:0]  rgn_q [NUM_RGN];
    logic [NUM_RGN-1:0] rgn_nz;

    orbus_decode i_decode (
        .clk      (clk),
        .rst      (rst),
        .top_bits (addr[ADDR_W-1 -: 2]),
        .sel      (sel)
    );

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
        localparam int IW = rgn_idx_w(g, ADDR_W);

        logic rgn_we;
        logic rgn_oe;

        assign rgn_we = sel[g] & wr_en;
        assign rgn_oe = sel[g] & rd_en;
        assign rgn_nz[g] = |rgn_q[g];

        orbus_region #(
            .IDX_W  (IW),
            .DATA_W (DATA_W)
        ) i_region (
            .clk  (clk),
            .rst  (rst),
            .we   (rgn_we),
            .oe   (rgn_oe),
            .idx  (addr[IW-1:0]),
            .din  (wdata),
            .dout (rgn_q[g])
        );
    end

    // Wide OR merge: deselected regions contribute zero.
    always_comb begin
        rdata = '0;
        for (int r = 0; r < NUM_RGN; r++) begin
            rdata = rdata | rgn_q[r];
        end
    end

    // R5: read strobe low on the last edge leaves the bus at zero
    assert_bus_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en) |-> (rdata == '0));

    // R6: at most one region drives a non-zero word
    assert_single_driver_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rgn_nz));

    // R7: output registers are clear after a reset edge
    assert_reset_clear_R7: assert property (@(posedge clk)
        $past(rst) |-> (rdata == '0));

endmodule

// File: tb/test_orbus_mem.sv
`timescale 1ns/1ps
module test_orbus_mem;

    localparam int AW = 10;
    localparam int DW = 16;
    localparam int NADDR = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    orbus_mem #(.ADDR_W(AW), .DATA_W(DW)) i_orbus_mem (
        .clk   (clk),
        .rst   (rst),
        .addr  (addr),
        .wdata (wdata),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .rdata (rdata)
    );

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 40503 + 12345) & 16'hFFFF);
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = AW'(a); wdata = d; wr_en = 1'b1; rd_en = 1'b0;
    endtask

    task automatic do_read(input int a, input logic [DW-1:0] exp, input string req);
        @(negedge clk);
        addr = AW'(a); wr_en = 1'b0; rd_en = 1'b1;
        @(negedge clk);
        check(req, rdata, exp);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R7 reset", rdata, '0);
        rst = 1'b0;

        // R1 R3: fill every address with a distinct pattern
        for (int a = 0; a < NADDR; a++) do_write(a, pat(a));
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        check("R5 idle after writes", rdata, '0);

        // R1 R4 R6: read every address back
        for (int a = 0; a < NADDR; a++) do_read(a, pat(a), "R4 R1 R6 sweep");

        // R5: strobe low, address of a non-zero word
        @(negedge clk);
        addr = AW'(10'h305); rd_en = 1'b0;
        @(negedge clk);
        check("R5 strobe low", rdata, '0);

        // R6: same low index in each region
        do_read(10'h005, pat(10'h005), "R6 region A");
        do_read(10'h105, pat(10'h105), "R6 region B");
        do_read(10'h205, pat(10'h205), "R6 region C low");
        do_read(10'h305, pat(10'h305), "R6 region C high");

        // R8: read and write the same word on one edge
        @(negedge clk);
        addr = AW'(10'h142); wdata = 16'hBEEF; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        check("R8 old data", rdata, pat(10'h142));
        wr_en = 1'b0; rd_en = 1'b0;
        do_read(10'h142, 16'hBEEF, "R8 new data");
        do_read(10'h042, pat(10'h042), "R3 other region untouched");

        // R7: reset overrides the read strobe
        @(negedge clk);
        addr = AW'(10'h3FF); rd_en = 1'b1; rst = 1'b1;
        @(negedge clk);
        check("R7 reset with read", rdata, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R4 read after reset", rdata, pat(10'h3FF));
        rd_en = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule